// File: doc/BRIEF.md
# Data cache stage with deferred store write

This block is the memory-stage portion of a direct-mapped data cache that never needs two cycles for a store. A store only looks up the tag array. If that lookup hits, the store's word address, data and byte enables are parked in a one-entry holding register. They reach the data array later, in the cycle when the next store that hits performs its own tag lookup. The data array therefore needs only one port, and it is never used for a tag check and a data write in the same access.

A load reads the tag and data arrays in the same cycle and reports hit and data combinationally. If the load addresses the word waiting in the holding register, the parked bytes replace the matching array bytes. Lines are brought in through a whole-line fill port. A store that misses does not allocate a line. A fill to the line held in the register keeps the parked bytes. A fill that replaces that line with another tag discards them. Dirty-line writeback and miss sequencing are handled outside this block.

Top module: `dcache_dw_stage`

## Requirements
- R1: While rst_ni is low, and after it is released, every line is invalid and the holding register is empty. Any request then misses: hit_o is 0 and load_data_o is 0.
- R2: A fill (fill_valid_i high) writes a 128-bit line to the index fill_addr_i[7:4], with word w at bits 32w+31:32w. It marks that line valid with tag fill_addr_i[31:8]. From the next cycle, a load to any word of the line hits and returns that word.
- R3: The lookup is combinational and gives its result in the cycle of the request. The byte address splits as tag [31:8], index [7:4], word [3:2] and byte [1:0]. The byte bits do not affect the result. hit_o is high only when req_valid_i is high, the indexed line is valid and its tag is equal to the address tag.
- R4: load_data_o is 0 unless a load request hits. This includes load misses, stores, idle cycles and fill cycles.
- R5: A store that hits raises hit_o in its own cycle and does not write the data array in that cycle. Its word address, data and byte enables are parked in the holding register. A store is signalled by req_store_i high.
- R6: A load to the parked word returns a merged word. For each byte lane i (bits 8i+7:8i), the parked byte is used where byte enable i was 1, and the array byte is used elsewhere.
- R7: When a store hits while another store is parked, the parked store is written into the array in that cycle, and the new store takes its place. Both values are visible from then on.
- R8: A store that misses writes nothing and allocates nothing. The parked store stays unchanged, and a later load to the missed address still misses.
- R9: A fill to the parked line's index with the same tag lays the parked bytes over the fill data. With a different tag, the fill discards them. In both cases the holding register ends up empty.
- R10: A fill to any other index leaves the parked store and its bypass intact.
- R11: Two stores in a row to the same word combine. The second store's enabled bytes overwrite the first store's, and the first store's other bytes stay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | CPU request present |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 32 | Byte address of the request |
| req_wdata_i | input | 32 | Store data |
| req_be_i | input | 4 | Store byte enables |
| hit_o | output | 1 | Request hits a valid line |
| load_data_o | output | 32 | Load result, 0 if not a load hit |
| fill_valid_i | input | 1 | Write a whole line |
| fill_addr_i | input | 32 | Any byte address inside the line being filled |
| fill_data_i | input | 128 | Line contents, word 0 in the low bits |

## Verification
The assertions assume that a fill and a CPU request never occur in the same cycle, because the external miss logic stalls the pipeline while it refills. They also assume that the fill port is never used to move the parked store between tags. The bench drives exactly one operation per cycle (load, store, fill or idle), so the exclusivity rule always holds. Expected data follow a simple rule: every filled word equals its own byte address. This makes every merge and every bypass result easy to predict by hand.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_WORD_W     = 32;
  localparam int unsigned DEF_LINE_WORDS = 4;
  localparam int unsigned DEF_LINES      = 16;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2
  } req_op_e;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int unsigned LINES = dcache_pkg::DEF_LINES,
  parameter int unsigned TAG_W = 24,
  localparam int unsigned INDEX_W = $clog2(LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INDEX_W-1:0] lk_index_i,
  input  logic [TAG_W-1:0]   lk_tag_i,
  output logic               lk_hit_o,
  input  logic               fill_en_i,
  input  logic [INDEX_W-1:0] fill_index_i,
  input  logic [TAG_W-1:0]   fill_tag_i
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        valid_q <= '0;
    else if (fill_en_i) valid_q[fill_index_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) tag_q[fill_index_i] <= fill_tag_i;
  end

  assign lk_hit_o = valid_q[lk_index_i] && (tag_q[lk_index_i] == lk_tag_i);

  assert_fill_sets_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |=> valid_q[$past(fill_index_i)]);
endmodule

// File: rtl/dc_data_array.sv
module dc_data_array #(
  parameter int unsigned LINES      = dcache_pkg::DEF_LINES,
  parameter int unsigned LINE_WORDS = dcache_pkg::DEF_LINE_WORDS,
  parameter int unsigned WORD_W     = dcache_pkg::DEF_WORD_W,
  localparam int unsigned INDEX_W = $clog2(LINES),
  localparam int unsigned WSEL_W  = $clog2(LINE_WORDS),
  localparam int unsigned BYTES   = WORD_W / 8,
  localparam int unsigned LINE_W  = WORD_W * LINE_WORDS
) (
  input  logic               clk_i,
  input  logic [INDEX_W-1:0] rd_index_i,
  input  logic [WSEL_W-1:0]  rd_word_i,
  output logic [WORD_W-1:0]  rd_data_o,
  input  logic               wr_en_i,
  input  logic [INDEX_W-1:0] wr_index_i,
  input  logic [WSEL_W-1:0]  wr_word_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic [BYTES-1:0]   wr_be_i,
  input  logic               fill_en_i,
  input  logic [INDEX_W-1:0] fill_index_i,
  input  logic [LINE_W-1:0]  fill_line_i
);
  logic [WORD_W-1:0] mem_q [LINES][LINE_WORDS];

  // word write is ordered after the fill so parked bytes land on top
  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      for (int w = 0; w < LINE_WORDS; w++)
        mem_q[fill_index_i][w] <= fill_line_i[w*WORD_W +: WORD_W];
    end
    if (wr_en_i) begin
      for (int b = 0; b < BYTES; b++)
        if (wr_be_i[b]) mem_q[wr_index_i][wr_word_i][b*8 +: 8] <= wr_data_i[b*8 +: 8];
    end
  end

  assign rd_data_o = mem_q[rd_index_i][rd_word_i];
endmodule

// File: rtl/dc_store_hold.sv
module dc_store_hold #(
  parameter int unsigned WADDR_W = 30,
  parameter int unsigned WORD_W  = dcache_pkg::DEF_WORD_W,
  localparam int unsigned BYTES = WORD_W / 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_en_i,
  input  logic [WADDR_W-1:0] load_waddr_i,
  input  logic [WORD_W-1:0]  load_data_i,
  input  logic [BYTES-1:0]   load_be_i,
  input  logic               drop_en_i,
  output logic               held_valid_o,
  output logic [WADDR_W-1:0] held_waddr_o,
  output logic [WORD_W-1:0]  held_data_o,
  output logic [BYTES-1:0]   held_be_o,
  input  logic [WADDR_W-1:0] rd_waddr_i,
  input  logic [WORD_W-1:0]  arr_data_i,
  output logic [WORD_W-1:0]  merged_o
);
  logic               valid_q;
  logic [WADDR_W-1:0] waddr_q;
  logic [WORD_W-1:0]  data_q;
  logic [BYTES-1:0]   be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      waddr_q <= '0;
      data_q  <= '0;
      be_q    <= '0;
    end else if (load_en_i) begin
      valid_q <= 1'b1;
      waddr_q <= load_waddr_i;
      data_q  <= load_data_i;
      be_q    <= load_be_i;
    end else if (drop_en_i) begin
      valid_q <= 1'b0;
    end
  end

  logic addr_match;
  assign addr_match = valid_q && (waddr_q == rd_waddr_i);

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign merged_o[b*8 +: 8] = (addr_match && be_q[b]) ? data_q[b*8 +: 8]
                                                         : arr_data_i[b*8 +: 8];
  end

  assign held_valid_o = valid_q;
  assign held_waddr_o = waddr_q;
  assign held_data_o  = data_q;
  assign held_be_o    = be_q;

  assert_park_captures_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> held_valid_o && (held_waddr_o == $past(load_waddr_i))
                  && (held_data_o == $past(load_data_i)));
endmodule

// File: rtl/dcache_dw_stage.sv
module dcache_dw_stage #(
  parameter int unsigned ADDR_W     = dcache_pkg::DEF_ADDR_W,
  parameter int unsigned WORD_W     = dcache_pkg::DEF_WORD_W,
  parameter int unsigned LINE_WORDS = dcache_pkg::DEF_LINE_WORDS,
  parameter int unsigned LINES      = dcache_pkg::DEF_LINES,
  localparam int unsigned BYTES   = WORD_W / 8,
  localparam int unsigned BOFF_W  = $clog2(BYTES),
  localparam int unsigned WSEL_W  = $clog2(LINE_WORDS),
  localparam int unsigned INDEX_W = $clog2(LINES),
  localparam int unsigned TAG_W   = ADDR_W - INDEX_W - WSEL_W - BOFF_W,
  localparam int unsigned WADDR_W = ADDR_W - BOFF_W,
  localparam int unsigned LINE_W  = WORD_W * LINE_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  input  logic [BYTES-1:0]  req_be_i,
  output logic              hit_o,
  output logic [WORD_W-1:0] load_data_o,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [LINE_W-1:0] fill_data_i
);
  import dcache_pkg::*;

  req_op_e op;
  assign op = !req_valid_i ? OP_IDLE : (req_store_i ? OP_STORE : OP_LOAD);

  logic [WADDR_W-1:0] req_waddr;
  logic [INDEX_W-1:0] req_index, fill_index, held_index;
  logic [TAG_W-1:0]   req_tag, fill_tag, held_tag;
  logic [WSEL_W-1:0]  req_word, held_word;

  assign req_waddr  = req_addr_i[ADDR_W-1:BOFF_W];
  assign req_word   = req_waddr[WSEL_W-1:0];
  assign req_index  = req_waddr[WSEL_W +: INDEX_W];
  assign req_tag    = req_waddr[WADDR_W-1 -: TAG_W];
  assign fill_index = fill_addr_i[BOFF_W+WSEL_W +: INDEX_W];
  assign fill_tag   = fill_addr_i[ADDR_W-1 -: TAG_W];

  logic               held_valid;
  logic [WADDR_W-1:0] held_waddr;
  logic [WORD_W-1:0]  held_data, arr_data, merged;
  logic [BYTES-1:0]   held_be;

  assign held_word  = held_waddr[WSEL_W-1:0];
  assign held_index = held_waddr[WSEL_W +: INDEX_W];
  assign held_tag   = held_waddr[WADDR_W-1 -: TAG_W];

  logic tag_hit, st_hit, fill_on_held, arr_wr_en;

  assign st_hit       = (op == OP_STORE) && tag_hit;
  assign fill_on_held = fill_valid_i && held_valid && (fill_index == held_index);
  // parked store retires on the next store hit, or onto a refill of its own line
  assign arr_wr_en    = held_valid && (st_hit || (fill_on_held && (fill_tag == held_tag)));

  dc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .lk_index_i(req_index), .lk_tag_i(req_tag), .lk_hit_o(tag_hit),
    .fill_en_i(fill_valid_i), .fill_index_i(fill_index), .fill_tag_i(fill_tag)
  );

  dc_data_array #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) u_data (
    .clk_i,
    .rd_index_i(req_index), .rd_word_i(req_word), .rd_data_o(arr_data),
    .wr_en_i(arr_wr_en), .wr_index_i(held_index), .wr_word_i(held_word),
    .wr_data_i(held_data), .wr_be_i(held_be),
    .fill_en_i(fill_valid_i), .fill_index_i(fill_index), .fill_line_i(fill_data_i)
  );

  dc_store_hold #(.WADDR_W(WADDR_W), .WORD_W(WORD_W)) u_hold (
    .clk_i, .rst_ni,
    .load_en_i(st_hit), .load_waddr_i(req_waddr), .load_data_i(req_wdata_i),
    .load_be_i(req_be_i), .drop_en_i(fill_on_held),
    .held_valid_o(held_valid), .held_waddr_o(held_waddr), .held_data_o(held_data),
    .held_be_o(held_be),
    .rd_waddr_i(req_waddr), .arr_data_i(arr_data), .merged_o(merged)
  );

  assign hit_o       = (op != OP_IDLE) && tag_hit;
  assign load_data_o = ((op == OP_LOAD) && tag_hit) ? merged : '0;

  assert_fill_req_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_valid_i && req_valid_i));

  assert_miss_keeps_park_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_store_i && !hit_o) |=>
      $stable(held_valid) && $stable(held_waddr) && $stable(held_data));

  assert_parked_resident_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_valid && req_valid_i && !req_store_i && (req_waddr == held_waddr)) |-> hit_o);
endmodule

// File: tb/tb_dcache_dw_stage.sv
module tb_dcache_dw_stage;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0, req_store_i = 1'b0;
  logic [31:0]  req_addr_i = '0, req_wdata_i = '0;
  logic [3:0]   req_be_i = '0;
  logic         hit_o;
  logic [31:0]  load_data_o;
  logic         fill_valid_i = 1'b0;
  logic [31:0]  fill_addr_i = '0;
  logic [127:0] fill_data_i = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dcache_dw_stage dut (.*);

  typedef struct packed {
    logic [1:0]  op;   // 0 idle, 1 load, 2 store, 3 fill
    logic [31:0] addr;
    logic [31:0] wd;
    logic [3:0]  be;
    logic        eh;
    logic [31:0] ed;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 32'h1230, 32'h0,        4'h0, 1'b0, 32'h0,        4'd1},  // R1 cold miss
    '{2'd3, 32'h1230, 32'h0,        4'h0, 1'b0, 32'h0,        4'd4},  // R4 fill cycle quiet
    '{2'd1, 32'h1234, 32'h0,        4'h0, 1'b1, 32'h1234,     4'd2},  // R2
    '{2'd1, 32'h123B, 32'h0,        4'h0, 1'b1, 32'h1238,     4'd3},  // R3 byte bits ignored
    '{2'd1, 32'h2234, 32'h0,        4'h0, 1'b0, 32'h0,        4'd3},  // R3 tag mismatch
    '{2'd2, 32'h1234, 32'hDEADBEEF, 4'hF, 1'b1, 32'h0,        4'd5},  // R5 store hit
    '{2'd1, 32'h1234, 32'h0,        4'h0, 1'b1, 32'hDEADBEEF, 4'd6},  // R6 full bypass
    '{2'd2, 32'h1238, 32'h11223344, 4'h3, 1'b1, 32'h0,        4'd7},  // R7 retire first
    '{2'd1, 32'h1234, 32'h0,        4'h0, 1'b1, 32'hDEADBEEF, 4'd7},  // R7 from array
    '{2'd1, 32'h1238, 32'h0,        4'h0, 1'b1, 32'h00003344, 4'd6},  // R6 byte merge
    '{2'd2, 32'h5550, 32'hFFFFFFFF, 4'hF, 1'b0, 32'h0,        4'd8},  // R8 store miss
    '{2'd1, 32'h5550, 32'h0,        4'h0, 1'b0, 32'h0,        4'd8},  // R8 no allocate
    '{2'd1, 32'h1238, 32'h0,        4'h0, 1'b1, 32'h00003344, 4'd8},  // R8 park intact
    '{2'd3, 32'h1250, 32'h0,        4'h0, 1'b0, 32'h0,        4'd10}, // R10 fill other idx
    '{2'd1, 32'h1238, 32'h0,        4'h0, 1'b1, 32'h00003344, 4'd10}, // R10
    '{2'd1, 32'h1258, 32'h0,        4'h0, 1'b1, 32'h1258,     4'd2},  // R2
    '{2'd3, 32'h1230, 32'h0,        4'h0, 1'b0, 32'h0,        4'd9},  // R9 same-tag refill
    '{2'd1, 32'h1238, 32'h0,        4'h0, 1'b1, 32'h00003344, 4'd9},  // R9 bytes kept
    '{2'd1, 32'h1234, 32'h0,        4'h0, 1'b1, 32'h1234,     4'd2},  // R2 line replaced
    '{2'd2, 32'h123C, 32'hAABBCCDD, 4'h8, 1'b1, 32'h0,        4'd5},  // R5
    '{2'd3, 32'h2230, 32'h0,        4'h0, 1'b0, 32'h0,        4'd9},  // R9 other-tag refill
    '{2'd1, 32'h223C, 32'h0,        4'h0, 1'b1, 32'h223C,     4'd9},  // R9
    '{2'd1, 32'h123C, 32'h0,        4'h0, 1'b0, 32'h0,        4'd9},  // R9 old line gone
    '{2'd3, 32'h1230, 32'h0,        4'h0, 1'b0, 32'h0,        4'd9},  // R9
    '{2'd1, 32'h123C, 32'h0,        4'h0, 1'b1, 32'h123C,     4'd9},  // R9 park discarded
    '{2'd2, 32'h1230, 32'h000000AA, 4'h1, 1'b1, 32'h0,        4'd11}, // R11
    '{2'd2, 32'h1230, 32'h0000BB00, 4'h2, 1'b1, 32'h0,        4'd11}, // R11
    '{2'd1, 32'h1230, 32'h0,        4'h0, 1'b1, 32'h0000BBAA, 4'd11}, // R11 combined
    '{2'd0, 32'h1230, 32'h0,        4'h0, 1'b0, 32'h0,        4'd4}   // R4 idle
  };

  function automatic logic [127:0] mk_line(logic [31:0] a);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = {a[31:4], 2'(w), 2'b00};
    return l;
  endfunction

  task automatic drive(input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] wd, input logic [3:0] be);
    req_valid_i  = (op == 2'd1) || (op == 2'd2);
    req_store_i  = (op == 2'd2);
    req_addr_i   = a;
    req_wdata_i  = wd;
    req_be_i     = be;
    fill_valid_i = (op == 2'd3);
    fill_addr_i  = a;
    fill_data_i  = mk_line(a);
  endtask

  task automatic check(input int rq, input logic eh, input logic [31:0] ed);
    checks++;
    if (hit_o !== eh || load_data_o !== ed) begin
      errors++;
      $display("FAIL R%0d: hit=%0b data=%h expected hit=%0b data=%h",
               rq, hit_o, load_data_o, eh, ed);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [31:0] a, input logic [31:0] wd,
                      input logic [3:0] be, input int rq, input logic eh,
                      input logic [31:0] ed);
    @(negedge clk_i);
    drive(op, a, wd, be);
    #1 check(rq, eh, ed);
  endtask

  initial begin
    // R1: outputs quiet while in reset even with a request
    @(negedge clk_i);
    drive(2'd1, 32'h1230, 32'h0, 4'h0);
    #1 check(1, 1'b0, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(2'd0, 32'h0, 32'h0, 4'h0);

    for (int i = 0; i < NV; i++)
      step(VECS[i].op, VECS[i].addr, VECS[i].wd, VECS[i].be,
           int'(VECS[i].rq), VECS[i].eh, VECS[i].ed);

    // R1: reset while a store is parked clears lines and the park
    step(2'd2, 32'h1234, 32'h55555555, 4'hF, 5, 1'b1, 32'h0);
    @(negedge clk_i);
    drive(2'd0, 32'h0, 32'h0, 4'h0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(2'd1, 32'h1234, 32'h0, 4'h0, 1, 1'b0, 32'h0);   // R1 line invalid
    step(2'd3, 32'h1230, 32'h0, 4'h0, 2, 1'b0, 32'h0);
    step(2'd1, 32'h1234, 32'h0, 4'h0, 1, 1'b1, 32'h1234); // R1 park gone
    step(2'd0, 32'h0, 32'h0, 4'h0, 4, 1'b0, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule